// File: doc/BRIEF.md
# CAN Protocol Error Flag and Code Capture

This block sits beside a CAN protocol engine and records the error events it reports. Eight single-cycle event pulses, one per error source, set sticky bits in an error-factor register. Seven further pulses, each naming a kind of bus error, land in an error-code register. A byte-wide register bus lets software read every register. Software acknowledges an event by writing a byte that holds 0 in the position of the flag to be cleared and 1 everywhere else.

A per-source enable register selects which factor flags raise the combined error status bit. That bit sits in bit 5 of the interrupt status register. Bit 5 of a separate interrupt enable register gates it onto the interrupt output. Bit 7 of the code register is a plain read/write mode bit. When it is set, new codes accumulate. When it is clear, each new bus error replaces the stored codes with only the latest ones.

The status bit is driven by a two-state machine:
- `IRQ_QUIET` moves to `IRQ_PENDING` when any enabled flag is pending.
- `IRQ_PENDING` returns to `IRQ_QUIET` when no enabled flag remains.

Register addresses:
- 0: error factors
- 1: factor enables
- 2: error codes with the mode bit
- 3: interrupt status (read-only)
- 4: interrupt enable

Top module: `canerr_flagbank`

## Requirements
- R1: After reset the factor flags, the enables, the codes, the mode bit and the interrupt enable are all 0. The status bit and the interrupt output are also 0.
- R2: An event pulse on factor input i sets flag bit i at the next clock edge, and the flag stays set until it is cleared. Bit order from 7 down to 0: bus lock, overload frame sent, receive overrun, bus-off recovery, bus-off entry, error passive, error warning, bus error.
- R3: A write to address 0 clears each flag whose wdata bit is 0 and leaves flags whose wdata bit is 1 unchanged.
- R4: When an event pulse and a clearing write hit the same factor flag in the same cycle, the flag ends up set.
- R5: With mode bit 7 of the code register at 1, code event pulses OR into code bits 6..0. Bit 6 is ACK delimiter, 5 dominant bit error, 4 recessive bit error, 3 CRC, 2 ACK, 1 form, 0 stuff. Codes already stored are kept.
- R6: With the mode bit at 0, any code event replaces bits 6..0 with exactly the codes of that event.
- R7: A write to address 2 stores wdata bit 7 as the mode bit. It clears code bits 6..0 whose wdata bit is 0. A code event in the same cycle still sets its bit.
- R8: The status bit (port err_isr, bit 5 at address 3) becomes 1 one cycle after an enabled flag is pending. It becomes 0 one cycle after the last enabled flag is cleared or disabled. Flags whose enable bit (address 1, same positions as the flags) is 0 never raise it.
- R9: err_irq is 1 exactly when the status bit is 1 and bit 5 of the interrupt enable register (address 4) is 1. Writes to address 3 have no effect.
- R10: Reads return flags (addr 0), enables (1), codes (2), status in bit 5 (3) and interrupt enable (4). All other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_factor | input | 8 | Single-cycle error source event pulses |
| ev_code | input | 7 | Single-cycle bus error code pulses |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr |
| err_flags | output | 8 | Error-factor flags |
| err_codes | output | 8 | Mode bit and error codes |
| err_isr | output | 1 | Combined error status bit |
| err_irq | output | 1 | Gated error interrupt |

## Verification
The assertions assume that event pulses and writes are sampled only at clock edges. They also assume that each write carries a stable address and data for the cycle in which the strobe is high. The stimulus meets this by changing every input on the falling edge and holding it for exactly one cycle. Pulses are released to 0 on the next falling edge, so no event is counted twice. Collisions between an event and a clearing write are produced on purpose, in the same cycle, because the priority between them is part of the specified behaviour.

// File: rtl/canerr_pkg.sv
package canerr_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        ADR_FACTOR = 3'd0,
        ADR_ENABLE = 3'd1,
        ADR_CODE   = 3'd2,
        ADR_ISTAT  = 3'd3,
        ADR_IENA   = 3'd4
    } reg_addr_e;

    typedef enum logic {
        IRQ_QUIET   = 1'b0,
        IRQ_PENDING = 1'b1
    } irq_state_e;
endpackage

// File: rtl/canerr_w0c_bank.sv
module canerr_w0c_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ev,
    input  logic         wr_clr,
    input  logic [W-1:0] wmask,
    output logic [W-1:0] flags
);
    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            logic flag_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    flag_q <= 1'b0;
                end else if (ev[i]) begin
                    flag_q <= 1'b1;
                end else if (wr_clr && !wmask[i]) begin
                    flag_q <= 1'b0;
                end
            end

            assign flags[i] = flag_q;

            AST_EVENT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
                ev[i] |=> flags[i]); // R2
            AST_ZERO_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_clr && !wmask[i] && !ev[i]) |=> !flags[i]); // R3
            AST_ONE_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
                (!ev[i] && (!wr_clr || wmask[i])) |=> (flags[i] == $past(flags[i]))); // R3
        end
    endgenerate
endmodule

// File: rtl/canerr_code_bank.sv
module canerr_code_bank #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ev,
    input  logic         wr,
    input  logic [W:0]   wdata,
    output logic [W:0]   codes
);
    logic         mode_q;
    logic [W-1:0] code_q;
    logic [W-1:0] keep_mask;
    logic [W-1:0] code_next;

    always_comb begin
        keep_mask = wr ? wdata[W-1:0] : {W{1'b1}};
        if (mode_q) begin
            code_next = (code_q & keep_mask) | ev;
        end else if (|ev) begin
            code_next = ev;
        end else begin
            code_next = code_q & keep_mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            code_q <= '0;
        end else begin
            if (wr) begin
                mode_q <= wdata[W];
            end
            code_q <= code_next;
        end
    end

    assign codes = {mode_q, code_q};

    AST_ACCUM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q && !wr) |=> ((codes[W-1:0] & $past(codes[W-1:0])) == $past(codes[W-1:0]))); // R5
    AST_OVERWRITE_LATEST: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && (|ev)) |=> (codes[W-1:0] == $past(ev))); // R6
    AST_MODE_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (codes[W] == $past(wdata[W]))); // R7
endmodule

// File: rtl/canerr_irq_fsm.sv
module canerr_irq_fsm
    import canerr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pend_any,
    output logic isr_err
);
    irq_state_e state_q;
    irq_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:   if (pend_any)  state_d = IRQ_PENDING;
            IRQ_PENDING: if (!pend_any) state_d = IRQ_QUIET;
            default:     state_d = IRQ_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        isr_err = 1'b0;
        unique case (state_q)
            IRQ_QUIET:   isr_err = 1'b0;
            IRQ_PENDING: isr_err = 1'b1;
            default:     isr_err = 1'b0;
        endcase
    end
endmodule

// File: rtl/canerr_flagbank.sv
module canerr_flagbank
    import canerr_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int IRQ_BIT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] ev_factor,
    input  logic [DATA_W-2:0] ev_code,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] err_flags,
    output logic [DATA_W-1:0] err_codes,
    output logic              err_isr,
    output logic              err_irq
);
    localparam int CODE_W = DATA_W - 1;

    logic [DATA_W-1:0] en_q;
    logic [DATA_W-1:0] ier_q;
    logic              wr_factor;
    logic              wr_code;
    logic              pend_any;

    assign wr_factor = wr_en && (addr == ADR_FACTOR);
    assign wr_code   = wr_en && (addr == ADR_CODE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= '0;
            ier_q <= '0;
        end else if (wr_en) begin
            if (addr == ADR_ENABLE) en_q  <= wdata;
            if (addr == ADR_IENA)   ier_q <= wdata;
        end
    end

    canerr_w0c_bank #(.W(DATA_W)) u_factor (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev     (ev_factor),
        .wr_clr (wr_factor),
        .wmask  (wdata),
        .flags  (err_flags)
    );

    canerr_code_bank #(.W(CODE_W)) u_code (
        .clk   (clk),
        .rst_n (rst_n),
        .ev    (ev_code),
        .wr    (wr_code),
        .wdata (wdata),
        .codes (err_codes)
    );

    assign pend_any = |(err_flags & en_q);

    canerr_irq_fsm u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend_any (pend_any),
        .isr_err  (err_isr)
    );

    assign err_irq = err_isr & ier_q[IRQ_BIT];

    always_comb begin
        rdata = '0;
        case (addr)
            ADR_FACTOR: rdata = err_flags;
            ADR_ENABLE: rdata = en_q;
            ADR_CODE:   rdata = err_codes;
            ADR_ISTAT:  rdata[IRQ_BIT] = err_isr;
            ADR_IENA:   rdata = ier_q;
            default:    rdata = '0;
        endcase
    end

    AST_ISR_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        (|(err_flags & en_q)) |=> err_isr); // R8
    AST_ISR_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(err_flags & en_q)) |=> !err_isr); // R8
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> (err_isr && ier_q[IRQ_BIT])); // R9
endmodule

// File: tb/canerr_flagbank_bench.sv
module canerr_flagbank_bench;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        int         sel;
        logic [7:0] val;
        string      tag;
    } exp_item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] ev_factor = '0;
    logic [6:0] ev_code = '0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] err_flags;
    logic [7:0] err_codes;
    logic       err_isr;
    logic       err_irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    exp_item_t exp_q[$];

    canerr_flagbank u_canerr_flagbank (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_factor (ev_factor),
        .ev_code   (ev_code),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .err_flags (err_flags),
        .err_codes (err_codes),
        .err_isr   (err_isr),
        .err_irq   (err_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic drive(input logic [7:0] f, input logic [6:0] c,
                         input logic w, input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        ev_factor = f;
        ev_code   = c;
        wr_en     = w;
        addr      = a;
        wdata     = d;
    endtask

    task automatic idle();
        drive(8'h00, 7'h00, 1'b0, 3'd0, 8'h00);
    endtask

    task automatic expect_v(input int sel, input logic [7:0] v, input string tag);
        exp_item_t it;
        it.sel = sel;
        it.val = v;
        it.tag = tag;
        exp_q.push_back(it);
    endtask

    function automatic logic [7:0] observe(input int sel);
        case (sel)
            0: return err_flags;
            1: return err_codes;
            2: return {7'd0, err_isr};
            3: return {7'd0, err_irq};
            default: return rdata;
        endcase
    endfunction

    // Monitor: compares queued expectations a quarter period after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            while (exp_q.size() > 0) begin
                exp_item_t it;
                logic [7:0] act;
                it = exp_q.pop_front();
                act = observe(it.sel);
                checks++;
                if (act !== it.val) begin
                    failures++;
                    $display("FAIL %s sel=%0d actual=%02h expected=%02h", it.tag, it.sel, act, it.val);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 3);
        rst_n = 1'b1;
        // R1 reset state
        drive(8'h00, 7'h00, 1'b0, 3'd1, 8'h00);
        expect_v(0, 8'h00, "R1 flags");
        expect_v(1, 8'h00, "R1 codes");
        expect_v(2, 8'h00, "R1 isr");
        expect_v(3, 8'h00, "R1 irq");
        expect_v(4, 8'h00, "R1 enable readback");
        // R2 bus error event, R6 overwrite code
        drive(8'h01, 7'h08, 1'b0, 3'd0, 8'h00);
        expect_v(0, 8'h01, "R2 bus error flag");
        expect_v(1, 8'h08, "R6 crc code");
        drive(8'h00, 7'h21, 1'b0, 3'd0, 8'h00);
        expect_v(0, 8'h01, "R2 flag sticky");
        expect_v(1, 8'h21, "R6 replaced codes");
        expect_v(2, 8'h00, "R8 disabled flag no isr");
        // R8 enable bus error and error passive
        drive(8'h00, 7'h00, 1'b1, 3'd1, 8'h05);
        expect_v(2, 8'h00, "R8 isr one cycle later");
        idle();
        expect_v(2, 8'h01, "R8 isr rises");
        expect_v(3, 8'h00, "R9 irq gated off");
        drive(8'h00, 7'h00, 1'b1, 3'd4, 8'h20);
        expect_v(3, 8'h01, "R9 irq gated on");
        drive(8'h00, 7'h00, 1'b1, 3'd3, 8'h00);
        expect_v(2, 8'h01, "R9 status write ignored");
        expect_v(3, 8'h01, "R9 irq after status write");
        // R2 multiple sources
        drive(8'h84, 7'h00, 1'b0, 3'd0, 8'h00);
        expect_v(0, 8'h85, "R2 bus lock and passive");
        // R3 clear bit 0 only
        drive(8'h00, 7'h00, 1'b1, 3'd0, 8'hFE);
        expect_v(0, 8'h84, "R3 zero clears one flag");
        // R4 event wins against clear
        drive(8'h04, 7'h00, 1'b1, 3'd0, 8'hFB);
        expect_v(0, 8'h84, "R4 event beats clear");
        // R3 then R8 fall
        drive(8'h00, 7'h00, 1'b1, 3'd0, 8'hFB);
        expect_v(0, 8'h80, "R3 clear passive");
        expect_v(2, 8'h01, "R8 isr held one cycle");
        idle();
        expect_v(2, 8'h00, "R8 isr falls");
        expect_v(3, 8'h00, "R9 irq falls");
        // R10 readback
        drive(8'h00, 7'h00, 1'b0, 3'd0, 8'h00);
        expect_v(4, 8'h80, "R10 read flags");
        drive(8'h00, 7'h00, 1'b0, 3'd2, 8'h00);
        expect_v(4, 8'h21, "R10 read codes");
        drive(8'h00, 7'h00, 1'b0, 3'd3, 8'h00);
        expect_v(4, 8'h00, "R10 read status");
        drive(8'h00, 7'h00, 1'b0, 3'd4, 8'h00);
        expect_v(4, 8'h20, "R10 read interrupt enable");
        drive(8'h00, 7'h00, 1'b0, 3'd6, 8'h00);
        expect_v(4, 8'h00, "R10 unmapped reads zero");
        // R7 set mode, clear codes
        drive(8'h00, 7'h00, 1'b1, 3'd2, 8'h80);
        expect_v(1, 8'h80, "R7 mode set codes cleared");
        // R5 accumulate
        drive(8'h00, 7'h01, 1'b0, 3'd0, 8'h00);
        expect_v(1, 8'h81, "R5 stuff accumulates");
        drive(8'h00, 7'h40, 1'b0, 3'd0, 8'h00);
        expect_v(1, 8'hC1, "R5 ack delimiter accumulates");
        drive(8'h00, 7'h00, 1'b1, 3'd2, 8'hBF);
        expect_v(1, 8'h81, "R7 zero clears code bit");
        drive(8'h00, 7'h01, 1'b1, 3'd2, 8'hFE);
        expect_v(1, 8'h81, "R7 code event beats clear");
        drive(8'h00, 7'h00, 1'b1, 3'd2, 8'h7F);
        expect_v(1, 8'h01, "R7 mode cleared by write");
        drive(8'h00, 7'h02, 1'b0, 3'd0, 8'h00);
        expect_v(1, 8'h02, "R6 overwrite after mode clear");
        // R2 and R3 all ones then all zeros
        drive(8'hFF, 7'h00, 1'b0, 3'd0, 8'h00);
        expect_v(0, 8'hFF, "R2 all sources");
        drive(8'h00, 7'h00, 1'b1, 3'd0, 8'h00);
        expect_v(0, 8'h00, "R3 clear all");
        idle();
        idle();
        idle();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule